// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on the master clock and measures how many master-clock cycles fit between successive rising edges of the frame (sample-rate) clock. From that count it decides whether the master clock runs at 256 or 384 times the sample rate. Once the ratio is decided, it issues a clock-enable that gives the downstream datapath an effective rate of 256 enables per frame.

The frame clock is locked in frequency to the master clock, but its phase is arbitrary. It is resynchronised into the master-clock domain before it is measured. A measurement is accepted into the committed ratio only after two consecutive periods agree.

The datapath is held in power-down in three cases:
- the standby input is high;
- no valid ratio has been committed;
- the frame clock has stopped toggling.

Typical operating points are sample rates of 32 to 48 kHz with a 64fs bit clock.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted, and until a ratio is committed, `pwr_down` is 1, `en_256` is 0 and `ratio_384` is 0.
- R2: A frame period of 252 to 260 master-clock cycles, inclusive, selects the 256 mode (`ratio_384`=0). In this mode `en_256` is 1 on every cycle.
- R3: A frame period of 380 to 388 cycles, inclusive, selects the 384 mode (`ratio_384`=1). In this mode `en_256` is 1 on exactly two of every three consecutive cycles, which gives 200 enables in any 300-cycle window.
- R4: A frame period outside both bands is invalid and leaves the block in power-down.
- R5: A ratio is committed only when two consecutive measured periods fall in the same band. After a single measurement the block is still powered down.
- R6: Once a ratio is committed, one measured period in the other valid band does not change `ratio_384` or `pwr_down`.
- R7: If 1024 master-clock cycles pass with no frame-clock rising edge, the committed ratio is dropped and `pwr_down` becomes 1.
- R8: `standby`=1 forces `pwr_down`=1 from the next master-clock cycle. Returning `standby` to 0 releases power-down one cycle later if a ratio is committed.
- R9: `en_256` is 0 whenever `pwr_down` is 1.
- R10: An invalid period measured while a ratio is committed drops the ratio and returns the block to power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register in the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous in phase to mclk |
| standby | input | 1 | 1 forces power-down, 0 allows normal operation |
| pwr_down | output | 1 | 1 holds the downstream datapath in power-down |
| ratio_384 | output | 1 | Committed ratio: 1 means 384fs, 0 means 256fs or none committed |
| en_256 | output | 1 | Clock-enable giving an effective 256fs rate |

## Verification
A frame-clock edge takes two synchroniser stages and one edge register to become a rise pulse. It then takes one more cycle to become a measurement and one more to update the committed ratio, so a lock shows about five mclk cycles after the rising edge that completes the second matching period. For this reason the bench waits whole frames plus margin, or a fixed count past a known edge, before it samples a lock or timeout result. Standby takes effect exactly one mclk cycle after it changes, and the bench samples it on the next falling edge. Enable patterns are counted over a 300-cycle window, a multiple of three, so the 384 mode must give exactly 200 enables whatever the starting phase.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_256  = 2'd1,
    RT_384  = 2'd2
  } ratio_t;
endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/mrd_period_meter.sv
module mrd_period_meter
  import mrd_pkg::*;
#(
  parameter int TIMEOUT    = 1024,
  parameter int LOW_RATIO  = 256,
  parameter int HIGH_RATIO = 384,
  parameter int TOL        = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise_i,
  output logic   meas_stb_o,
  output ratio_t meas_cls_o,
  output logic   lost_o
);
  localparam int CNT_W = $clog2(TIMEOUT) + 1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] LO_MIN  = CNT_W'(LOW_RATIO - TOL);
  localparam logic [CNT_W-1:0] LO_MAX  = CNT_W'(LOW_RATIO + TOL);
  localparam logic [CNT_W-1:0] HI_MIN  = CNT_W'(HIGH_RATIO - TOL);
  localparam logic [CNT_W-1:0] HI_MAX  = CNT_W'(HIGH_RATIO + TOL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;
  logic             stb_q, stb_d;
  ratio_t           cls_q, cls_d;
  logic [CNT_W-1:0] period;

  always_comb begin
    period = cnt_q + CNT_W'(1);
    cnt_d  = cnt_q;
    ref_d  = ref_q;
    stb_d  = 1'b0;
    cls_d  = cls_q;
    lost_o = 1'b0;
    if (rise_i) begin
      cnt_d = '0;
      ref_d = 1'b1;
      if (ref_q) begin
        stb_d = 1'b1;
        if (period >= LO_MIN && period <= LO_MAX)      cls_d = RT_256;
        else if (period >= HI_MIN && period <= HI_MAX) cls_d = RT_384;
        else                                           cls_d = RT_NONE;
      end
    end else if (ref_q) begin
      if (cnt_q == CNT_LIM) begin
        ref_d  = 1'b0;
        lost_o = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
      stb_q <= 1'b0;
      cls_q <= RT_NONE;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
      stb_q <= stb_d;
      cls_q <= cls_d;
    end
  end

  assign meas_stb_o = stb_q;
  assign meas_cls_o = cls_q;
endmodule

// File: rtl/mrd_ratio_lock.sv
module mrd_ratio_lock
  import mrd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   meas_stb_i,
  input  ratio_t meas_cls_i,
  input  logic   lost_i,
  output ratio_t ratio_o
);
  ratio_t ratio_q, ratio_d;
  ratio_t cand_q, cand_d;
  logic   candv_q, candv_d;

  always_comb begin
    ratio_d = ratio_q;
    cand_d  = cand_q;
    candv_d = candv_q;
    if (lost_i) begin
      ratio_d = RT_NONE;
      candv_d = 1'b0;
    end else if (meas_stb_i) begin
      if (meas_cls_i == RT_NONE) begin
        ratio_d = RT_NONE;
        candv_d = 1'b0;
      end else begin
        if (candv_q && cand_q == meas_cls_i) ratio_d = meas_cls_i;
        cand_d  = meas_cls_i;
        candv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RT_NONE;
      cand_q  <= RT_NONE;
      candv_q <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      cand_q  <= cand_d;
      candv_q <= candv_d;
    end
  end

  assign ratio_o = ratio_q;
endmodule

// File: rtl/mrd_enable_gen.sv
module mrd_enable_gen
  import mrd_pkg::*;
#(
  parameter int LOW_RATIO  = 256,
  parameter int HIGH_RATIO = 384
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd_i,
  input  ratio_t ratio_i,
  output logic   en_o
);
  localparam int PH_N = HIGH_RATIO / (HIGH_RATIO - LOW_RATIO);
  localparam int PH_W = $clog2(PH_N);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            run_hi;

  always_comb begin
    run_hi = !pd_i && (ratio_i == RT_384);
    if (!run_hi)                phase_d = '0;
    else if (phase_q == PH_LAST) phase_d = '0;
    else                        phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign en_o = !pd_i && ((ratio_i == RT_256) ||
                          (ratio_i == RT_384 && phase_q != PH_LAST));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 1024,
  parameter int LOW_RATIO   = 256,
  parameter int HIGH_RATIO  = 384,
  parameter int TOL         = 4
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic standby,
  output logic pwr_down,
  output logic ratio_384,
  output logic en_256
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       rise_w;
  logic       meas_stb_w;
  ratio_t     meas_cls_w;
  logic       lost_w;
  ratio_t     ratio_w;
  logic       stby_q, stby_d;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (mclk),
    .rst_n    (rst_int_n),
    .async_in (frame_clk),
    .rise_o   (rise_w)
  );

  mrd_period_meter #(
    .TIMEOUT    (TIMEOUT),
    .LOW_RATIO  (LOW_RATIO),
    .HIGH_RATIO (HIGH_RATIO),
    .TOL        (TOL)
  ) u_meter (
    .clk        (mclk),
    .rst_n      (rst_int_n),
    .rise_i     (rise_w),
    .meas_stb_o (meas_stb_w),
    .meas_cls_o (meas_cls_w),
    .lost_o     (lost_w)
  );

  mrd_ratio_lock u_lock (
    .clk        (mclk),
    .rst_n      (rst_int_n),
    .meas_stb_i (meas_stb_w),
    .meas_cls_i (meas_cls_w),
    .lost_i     (lost_w),
    .ratio_o    (ratio_w)
  );

  always_comb stby_d = standby;

  always_ff @(posedge mclk or negedge rst_int_n) begin
    if (!rst_int_n) stby_q <= 1'b1;
    else            stby_q <= stby_d;
  end

  assign pwr_down  = stby_q | (ratio_w == RT_NONE);
  assign ratio_384 = (ratio_w == RT_384);

  mrd_enable_gen #(
    .LOW_RATIO  (LOW_RATIO),
    .HIGH_RATIO (HIGH_RATIO)
  ) u_en (
    .clk     (mclk),
    .rst_n   (rst_int_n),
    .pd_i    (pwr_down),
    .ratio_i (ratio_w),
    .en_o    (en_256)
  );
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic pwr_down,
  input logic ratio_384,
  input logic en_256,
  input logic lost
);
  AST_STANDBY_FORCES_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(standby) |-> pwr_down); // R8

  AST_NO_EN_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !en_256); // R9

  AST_FULL_RATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !ratio_384) |-> en_256); // R2

  AST_TWO_OF_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_384 && !pwr_down && $past(ratio_384 && !pwr_down) &&
     $past(ratio_384 && !pwr_down, 2))
    |-> ($countones({en_256, $past(en_256), $past(en_256, 2)}) == 2)); // R3

  AST_LOST_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lost) |-> pwr_down); // R7

  AST_RATIO_ONLY_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_384 && !$past(ratio_384)) |-> !$past(lost)); // R7
endmodule

bind mclk_ratio_detect mrd_checker chk_i (
  .clk       (mclk),
  .rst_n     (rst_n),
  .standby   (standby),
  .pwr_down  (pwr_down),
  .ratio_384 (ratio_384),
  .en_256    (en_256),
  .lost      (lost_w)
);

// File: tb/mclk_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_detect_tb_top;
  logic mclk;
  logic rst_n;
  logic frame_clk;
  logic standby;
  logic pwr_down;
  logic ratio_384;
  logic en_256;

  int n_checks;
  int n_errors;
  int fper;
  bit done;

  localparam int VEC_N = 11;
  localparam int V_PER  [VEC_N] = '{256, 252, 260, 384, 380, 388, 251, 261, 320, 379, 389};
  localparam int V_R384 [VEC_N] = '{0,   0,   0,   1,   1,   1,   0,   0,   0,   0,   0};
  localparam int V_PD   [VEC_N] = '{0,   0,   0,   0,   0,   0,   1,   1,   1,   1,   1};

  mclk_ratio_detect dut_i (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .frame_clk (frame_clk),
    .standby   (standby),
    .pwr_down  (pwr_down),
    .ratio_384 (ratio_384),
    .en_256    (en_256)
  );

  initial mclk = 1'b0;
  always #2 mclk = ~mclk;

  initial begin
    frame_clk = 1'b0;
    fper = 0;
    forever begin
      if (fper == 0) begin
        @(negedge mclk);
      end else begin
        int cur;
        cur = fper;
        frame_clk = 1'b1;
        repeat (cur / 2) @(negedge mclk);
        frame_clk = 1'b0;
        repeat (cur - cur / 2) @(negedge mclk);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);
  endtask

  task automatic count_en(output int cnt);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge mclk);
      if (en_256) cnt++;
    end
  endtask

  task automatic lock_at(input int per);
    fper = per;
    do_reset();
    repeat (7 * per + 20) @(negedge mclk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ecnt;
    int bad;
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    standby = 1'b0;
    rst_n = 1'b0;

    // R1: reset state
    repeat (3) @(negedge mclk);
    chk("R1 pwr_down in reset", int'(pwr_down), 1);
    chk("R1 en_256 in reset", int'(en_256), 0);
    chk("R1 ratio_384 in reset", int'(ratio_384), 0);

    // Table of periods: R2 / R3 / R4 / R9
    for (int i = 0; i < VEC_N; i++) begin
      lock_at(V_PER[i]);
      chk($sformatf("R4 pwr_down period %0d", V_PER[i]), int'(pwr_down), V_PD[i]);
      chk($sformatf("R3 ratio_384 period %0d", V_PER[i]), int'(ratio_384), V_R384[i]);
      count_en(ecnt);
      chk($sformatf("R2 R9 enable count period %0d", V_PER[i]), ecnt,
          V_PD[i] != 0 ? 0 : (V_R384[i] != 0 ? 200 : 300));
    end

    // R5: one measurement is not enough
    fper = 0;
    repeat (400) @(negedge mclk);
    do_reset();
    fper = 384;
    @(posedge frame_clk);
    repeat (384 + 200) @(negedge mclk);
    chk("R5 pwr_down after one period", int'(pwr_down), 1);
    repeat (384) @(negedge mclk);
    chk("R5 pwr_down after two periods", int'(pwr_down), 0);
    chk("R5 ratio_384 after two periods", int'(ratio_384), 1);

    // R6: a single period in the other band is ignored
    @(posedge frame_clk);
    fper = 256;
    @(posedge frame_clk);
    fper = 384;
    bad = 0;
    for (int k = 0; k < 5 * 384; k++) begin
      @(negedge mclk);
      if (!ratio_384 || pwr_down) bad++;
    end
    chk("R6 cycles with changed ratio or power-down", bad, 0);

    // R8 / R9: standby
    @(negedge mclk);
    standby = 1'b1;
    @(negedge mclk);
    chk("R8 pwr_down one cycle after standby", int'(pwr_down), 1);
    chk("R9 en_256 in standby", int'(en_256), 0);
    standby = 1'b0;
    @(negedge mclk);
    chk("R8 pwr_down one cycle after standby release", int'(pwr_down), 0);

    // R10: invalid period while committed
    lock_at(256);
    chk("R10 locked before invalid", int'(pwr_down), 0);
    fper = 320;
    repeat (4 * 320) @(negedge mclk);
    chk("R10 pwr_down after invalid period", int'(pwr_down), 1);

    // R7: frame clock stops
    lock_at(256);
    @(posedge frame_clk);
    fper = 0;
    repeat (1000) @(negedge mclk);
    chk("R7 still up before timeout", int'(pwr_down), 0);
    repeat (100) @(negedge mclk);
    chk("R7 pwr_down after timeout", int'(pwr_down), 1);
    chk("R7 en_256 after timeout", int'(en_256), 0);

    finish_run();
  end
endmodule